// File: doc/BRIEF.md
# Multi-Bank Clock Divider with Coincidence Pulse

This block takes one fast source clock and derives from it twelve divided clocks, organised as three banks of four, plus a separate feedback clock. A front-stage halving divider can be switched out, so the banks count either every source cycle or every second one. Each bank picks its ratio with a 2-bit code, and the feedback output picks its ratio with a 3-bit code. All dividers restart from one shared phase when the master reset is released.

A coincidence pulse, one source cycle wide, is raised whenever banks A and C both produce a rising edge in the same cycle. It therefore repeats at the least common multiple of the two bank periods. A polarity input can flip the two upper outputs of bank C. A 12-bit enable word, loaded serially through a slow clock/data pair that is sampled in the source domain, switches individual bank outputs on or off. The active-low master reset clears all state and forces every output low.

Top module: `clkdiv_banks`

## Requirements
- R1: A bank output runs at its ratio N in ticks. It is high for the first N/2 ticks of each period and low for the rest. The bank select codes map as follows: 2'b00 gives 4, 2'b01 gives 6, 2'b10 gives 8 and 2'b11 gives 12.
- R2: The feedback output follows the same waveform rule as R1. Its 3-bit select codes 0 through 7 give ratios 2, 4, 6, 8, 10, 12, 16 and 24. It is never affected by the enable word.
- R3: With `pre_bypass` high, every source cycle is a tick. With it low, only every second source cycle is a tick, and the first tick comes on the second rising source edge after reset release.
- R4: On the first tick after reset release, every divider (all banks and feedback) begins its high phase together. The coincidence pulse is high in that cycle.
- R5: `sync_out` is high for exactly one source cycle when banks A and C both start their high phase in that cycle, and it is low at all other times.
- R6: While `inv_c23` is high, outputs C2 and C3 carry the inverted bank C waveform. C0 and C1 are never inverted.
- R7: While `rst_n_oe` is low, every output is low (including inverted C outputs), and all divider state is cleared.
- R8: On each rising edge of `ser_clk`, one bit of `ser_dat` shifts into the 12-bit enable word, most significant bit first. The edge is seen through a two-stage synchroniser, so each level of `ser_clk` must be held for at least 3 source cycles. Bit k enables output k, with bits 0–3 mapping to A0–A3, 4–7 to B0–B3 and 8–11 to C0–C3. After 12 shifts, the first bit sent lands on C3.
- R9: An output whose enable bit is 0 is held low, even when it would otherwise be inverted. `sync_out` and `q_fb` are not gated by the enable word.
- R10: The enable word resets to all ones. Serial clock edges that occur while `rst_n_oe` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock, the only clock domain |
| rst_n_oe | input | 1 | Active-low master reset and output gate |
| pre_bypass | input | 1 | High: skip the halving pre-stage |
| sel_a | input | 2 | Bank A ratio code |
| sel_b | input | 2 | Bank B ratio code |
| sel_c | input | 2 | Bank C ratio code |
| sel_fb | input | 3 | Feedback ratio code |
| inv_c23 | input | 1 | Invert outputs C2 and C3 |
| ser_clk | input | 1 | Slow serial clock for the enable word |
| ser_dat | input | 1 | Serial data for the enable word |
| q_a | output | 4 | Bank A clocks |
| q_b | output | 4 | Bank B clocks |
| q_c | output | 4 | Bank C clocks |
| q_fb | output | 1 | Feedback clock |
| sync_out | output | 1 | Coincidence pulse for banks A and C |

## Verification
A divider that has drifted off the common phase shows up first as a missing coincidence pulse on the first tick after release. Within one A/C common period, which is at most 24 ticks or 48 source cycles, it also shows as a bank edge that is out of step with the feedback clock. A corrupted enable bit appears as a bank output stuck low, or not stuck low, within one bank period of the load. A pre-stage that is in the wrong phase shifts every edge by one source cycle, and that is visible at the first tick. The bench models every output in every cycle from the requirements alone. It mixes random ratios, polarity and enable words with directed checks of reset and of serial edges applied during reset.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
   localparam int BANKS     = 3;
   localparam int PER_BANK  = 4;
   localparam int NOUT      = BANKS * PER_BANK;
   localparam int BSEL_W    = 2;
   localparam int FSEL_W    = 3;
   localparam int INV_BANK  = 2;   // bank C
   localparam int INV_FIRST = 2;   // C2 and C3 invertible
   localparam int CO_X      = 0;   // coincidence bank A
   localparam int CO_Y      = 2;   // coincidence bank C

   function automatic bit ratio_legal(input int r);
      return (r >= 2) && ((r % 2) == 0);
   endfunction
endpackage

// File: rtl/clkdiv_prediv.sv
module clkdiv_prediv #(
   parameter int PRE_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bypass,
   output logic tick
);
   localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

   generate
      if (PRE_DIV < 1) begin : g_bad
         $error("PRE_DIV must be at least 1");
      end
      if (PRE_DIV == 1) begin : g_none
         assign tick = 1'b1;
      end else begin : g_div
         logic [PW-1:0] pc;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pc <= '0;
            else if (pc == PW'(PRE_DIV - 1)) pc <= '0;
            else pc <= pc + PW'(1);
         end
         assign tick = bypass | (pc == PW'(PRE_DIV - 1));

         assert_prediv_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!bypass && tick) |=> (bypass || !tick));
      end
   endgenerate
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
   parameter int RW     = 8,
   parameter int SEL_W  = 2,
   parameter logic [(1<<SEL_W)*RW-1:0] RATIOS = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [SEL_W-1:0] sel,
   output logic             lvl,
   output logic             rise
);
   import clkdiv_pkg::*;
   localparam int NR = 1 << SEL_W;

   generate
      for (genvar k = 0; k < NR; k++) begin : g_chk
         if (!ratio_legal(int'(RATIOS[k*RW +: RW]))) begin : g_bad
            $error("divider ratio %0d is not an even value >= 2", k);
         end
      end
   endgenerate

   logic [RW-1:0] ratio, half, cnt, cnt_nx;
   logic          run;

   assign ratio = RATIOS[sel*RW +: RW];
   assign half  = ratio >> 1;

   always_comb begin
      if (!run || cnt >= ratio - RW'(1)) cnt_nx = '0;
      else                               cnt_nx = cnt + RW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run  <= 1'b0;
         cnt  <= '0;
         lvl  <= 1'b0;
         rise <= 1'b0;
      end else begin
         rise <= 1'b0;
         if (tick) begin
            run  <= 1'b1;
            cnt  <= cnt_nx;
            lvl  <= (cnt_nx < half);
            rise <= (cnt_nx == '0);
         end
      end
   end

   assert_rise_is_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rise |-> lvl);
   assert_high_starts_on_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl && !$past(lvl)) |-> rise);
   assert_first_tick_rises_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && tick) |=> rise);
   assert_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (!lvl && !rise));
endmodule

// File: rtl/clkdiv_serial_en.sv
module clkdiv_serial_en #(
   parameter int NBITS = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sclk,
   input  logic             sdat,
   output logic [NBITS-1:0] en
);
   logic [2:0] sc;
   logic [1:0] sd;
   logic       shift;

   generate
      if (NBITS < 2) begin : g_bad
         $error("NBITS must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sc <= '0;
         sd <= '0;
      end else begin
         sc <= {sc[1:0], sclk};
         sd <= {sd[0], sdat};
      end
   end

   assign shift = sc[1] & ~sc[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en <= '1;
      else if (shift) en <= {en[NBITS-2:0], sd[1]};
   end

   assert_shift_takes_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      shift |=> (en[0] == $past(sd[1])));
   assert_hold_without_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !shift |=> $stable(en));
endmodule

// File: rtl/clkdiv_banks.sv
module clkdiv_banks #(
   parameter int RW      = 8,
   parameter int PRE_DIV = 2,
   parameter logic [4*RW-1:0] BANK_RATIOS = {8'd12, 8'd8, 8'd6, 8'd4},
   parameter logic [8*RW-1:0] FB_RATIOS   =
      {8'd24, 8'd16, 8'd12, 8'd10, 8'd8, 8'd6, 8'd4, 8'd2}
) (
   input  logic       clk_src,
   input  logic       rst_n_oe,
   input  logic       pre_bypass,
   input  logic [1:0] sel_a,
   input  logic [1:0] sel_b,
   input  logic [1:0] sel_c,
   input  logic [2:0] sel_fb,
   input  logic       inv_c23,
   input  logic       ser_clk,
   input  logic       ser_dat,
   output logic [3:0] q_a,
   output logic [3:0] q_b,
   output logic [3:0] q_c,
   output logic       q_fb,
   output logic       sync_out
);
   import clkdiv_pkg::*;

   logic              tick;
   logic [BSEL_W-1:0] bsel [BANKS];
   logic              blvl [BANKS];
   logic              brise[BANKS];
   logic              fb_lvl, fb_rise;
   logic [NOUT-1:0]   en, q_all;

   assign bsel[0] = sel_a;
   assign bsel[1] = sel_b;
   assign bsel[2] = sel_c;

   clkdiv_prediv #(.PRE_DIV(PRE_DIV)) u_pre (
      .clk(clk_src), .rst_n(rst_n_oe), .bypass(pre_bypass), .tick(tick));

   generate
      for (genvar b = 0; b < BANKS; b++) begin : g_bank
         clkdiv_counter #(.RW(RW), .SEL_W(BSEL_W), .RATIOS(BANK_RATIOS)) u_div (
            .clk(clk_src), .rst_n(rst_n_oe), .tick(tick), .sel(bsel[b]),
            .lvl(blvl[b]), .rise(brise[b]));

         for (genvar i = 0; i < PER_BANK; i++) begin : g_out
            localparam int  IDX = b * PER_BANK + i;
            localparam bit  INV = (b == INV_BANK) && (i >= INV_FIRST);
            if (INV) begin : g_inv
               assign q_all[IDX] = rst_n_oe & en[IDX] & (blvl[b] ^ inv_c23);
            end else begin : g_pass
               assign q_all[IDX] = rst_n_oe & en[IDX] & blvl[b];
            end
         end
      end
   endgenerate

   clkdiv_counter #(.RW(RW), .SEL_W(FSEL_W), .RATIOS(FB_RATIOS)) u_fb (
      .clk(clk_src), .rst_n(rst_n_oe), .tick(tick), .sel(sel_fb),
      .lvl(fb_lvl), .rise(fb_rise));

   clkdiv_serial_en #(.NBITS(NOUT)) u_en (
      .clk(clk_src), .rst_n(rst_n_oe), .sclk(ser_clk), .sdat(ser_dat), .en(en));

   assign q_a      = q_all[0 +: PER_BANK];
   assign q_b      = q_all[PER_BANK +: PER_BANK];
   assign q_c      = q_all[2*PER_BANK +: PER_BANK];
   assign q_fb     = rst_n_oe & fb_lvl;
   assign sync_out = rst_n_oe & brise[CO_X] & brise[CO_Y];

   assert_sync_on_high_R5: assert property (@(posedge clk_src) disable iff (!rst_n_oe)
      sync_out |-> (blvl[CO_X] && blvl[CO_Y]));
   assert_sync_single_R5: assert property (@(posedge clk_src) disable iff (!rst_n_oe)
      sync_out |=> !sync_out);
   assert_fb_rise_high_R2: assert property (@(posedge clk_src) disable iff (!rst_n_oe)
      fb_rise |-> q_fb);
endmodule

// File: tb/sim_clkdiv_banks.sv
module sim_clkdiv_banks;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic       rst_n_oe = 1'b0, pre_bypass = 1'b0, inv_c23 = 1'b0;
   logic       ser_clk = 1'b0, ser_dat = 1'b0;
   logic [1:0] sel_a = '0, sel_b = '0, sel_c = '0;
   logic [2:0] sel_fb = '0;
   logic [3:0] q_a, q_b, q_c;
   logic       q_fb, sync_out;

   clkdiv_banks u0 (
      .clk_src(clk), .rst_n_oe(rst_n_oe), .pre_bypass(pre_bypass),
      .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .sel_fb(sel_fb),
      .inv_c23(inv_c23), .ser_clk(ser_clk), .ser_dat(ser_dat),
      .q_a(q_a), .q_b(q_b), .q_c(q_c), .q_fb(q_fb), .sync_out(sync_out));

   int unsigned n_chk = 0, n_fail = 0;
   int          e_cnt = 0, ticks = 0;
   logic [11:0] exp_en = '1;
   string       ctx = "R1";
   bit          finished = 1'b0;

   function automatic int bank_ratio(input logic [1:0] s);
      case (s)
         2'b00:   return 4;
         2'b01:   return 6;
         2'b10:   return 8;
         default: return 12;
      endcase
   endfunction

   function automatic int fb_ratio(input logic [2:0] s);
      case (s)
         3'd0: return 2;   3'd1: return 4;   3'd2: return 6;   3'd3: return 8;
         3'd4: return 10;  3'd5: return 12;  3'd6: return 16;  default: return 24;
      endcase
   endfunction

   function automatic logic lvl_of(input int t, input int n);
      if (t == 0) return 1'b0;
      return (((t - 1) % n) < (n / 2));
   endfunction

   function automatic logic rise_of(input bit tk, input int t, input int n);
      return tk && (t > 0) && (((t - 1) % n) == 0);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, e_cnt);
      end
   endtask

   task automatic step(input bit banks);
      bit tk;
      logic la, lb, lc, lf, ra, rc;
      logic [3:0] ea, eb, ec;
      @(posedge clk);
      tk = 1'b0;
      if (rst_n_oe) begin
         e_cnt++;
         tk = pre_bypass || (e_cnt % 2 == 0);
         if (tk) ticks++;
      end else begin
         e_cnt = 0;
         ticks = 0;
      end
      @(negedge clk);
      if (!rst_n_oe) begin
         check("R7 reset outputs", {19'd0, q_a, q_b, q_c, q_fb}, 32'd0);
         check("R7 reset sync", {31'd0, sync_out}, 32'd0);
         return;
      end
      la = lvl_of(ticks, bank_ratio(sel_a));
      lb = lvl_of(ticks, bank_ratio(sel_b));
      lc = lvl_of(ticks, bank_ratio(sel_c));
      lf = lvl_of(ticks, fb_ratio(sel_fb));
      ra = rise_of(tk, ticks, bank_ratio(sel_a));
      rc = rise_of(tk, ticks, bank_ratio(sel_c));
      for (int i = 0; i < 4; i++) begin
         ea[i] = la & exp_en[i];
         eb[i] = lb & exp_en[4 + i];
         ec[i] = ((i >= 2) ? (lc ^ inv_c23) : lc) & exp_en[8 + i];
      end
      check("R2 R3 feedback", {31'd0, q_fb}, {31'd0, lf});
      check("R5 sync", {31'd0, sync_out}, {31'd0, ra & rc});
      if (tk && ticks == 1) check("R4 common first rise", {30'd0, sync_out, q_fb}, 32'd3);
      if (banks) begin
         check({ctx, " R1 bank A"}, {28'd0, q_a}, {28'd0, ea});
         check({ctx, " R1 bank B"}, {28'd0, q_b}, {28'd0, eb});
         check({ctx, " R6 R9 bank C"}, {28'd0, q_c}, {28'd0, ec});
      end
   endtask

   task automatic load_en(input logic [11:0] v);
      for (int i = 11; i >= 0; i--) begin
         ser_dat = v[i];
         ser_clk = 1'b0;
         repeat (3) step(1'b0);
         ser_clk = 1'b1;
         repeat (3) step(1'b0);
      end
      ser_clk = 1'b0;
      repeat (4) step(1'b0);
      exp_en = v;
   endtask

   task automatic segment(input logic byp, input logic [1:0] a, input logic [1:0] b,
                          input logic [1:0] c, input logic [2:0] f, input logic inv,
                          input bit do_load, input logic [11:0] v, input int len);
      rst_n_oe = 1'b0;
      pre_bypass = byp; sel_a = a; sel_b = b; sel_c = c; sel_fb = f; inv_c23 = inv;
      repeat (3) step(1'b1);
      exp_en = '1;
      rst_n_oe = 1'b1;
      if (do_load) begin
         ctx = "R8 loaded";
         load_en(v);
      end else begin
         ctx = "R10 default";
      end
      repeat (len) step(1'b1);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      // reset state with inversion requested: all low
      inv_c23 = 1'b1;
      repeat (4) step(1'b1);
      // directed: A=6, C=12 (sync every 12 ticks), bypass, no load
      segment(1'b1, 2'b01, 2'b00, 2'b11, 3'd7, 1'b0, 1'b0, 12'h000, 120);
      // directed: A=8, C=6, halving on, inverted, disable C2 and A1 only
      segment(1'b0, 2'b10, 2'b11, 2'b01, 3'd4, 1'b1, 1'b1, 12'hBFD, 160);
      // directed R10: serial edges during reset are ignored
      rst_n_oe = 1'b0;
      ser_dat = 1'b0;
      for (int k = 0; k < 14; k++) begin
         ser_clk = 1'b1; repeat (3) step(1'b1);
         ser_clk = 1'b0; repeat (3) step(1'b1);
      end
      exp_en = '1;
      ctx = "R10 ignored in reset";
      rst_n_oe = 1'b1;
      repeat (60) step(1'b1);
      // random segments
      for (int s = 0; s < 12; s++) begin
         segment(1'($urandom), 2'($urandom), 2'($urandom), 2'($urandom), 3'($urandom),
                 1'($urandom), 1'($urandom), 12'($urandom), 100 + int'($urandom % 100));
      end
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule